// File: doc/BRIEF.md
# Receive descriptor ring writeback engine

The engine moves received Ethernet frames from a byte-wide receive stream into host memory under control of a ring of 16-byte receive descriptors. Each descriptor holds a status word at offset 0, a tag word at offset 4, a buffer pointer at offset 8 and an upper pointer word at offset 12. This block uses only the lower pointer, so buffers sit in a 32-bit address space. Software hands a descriptor to the engine by setting the ownership bit and writing the buffer size into the length field. The engine stores the frame into that buffer and then rewrites the status word. The rewritten word carries the stored length (CRC bytes included) and the error causes, and has the ownership bit cleared.

While no frame is in progress, the engine re-reads the status word and the buffer pointer of the current descriptor in alternating cycles and keeps a cached copy of both. On a frame start it decides from the cache alone. If the descriptor is owned, the frame is written byte by byte into the buffer. If it is not owned, the frame is discarded and a missed-frame counter advances. The ring starts at a 256-byte aligned base. It steps by 16 bytes per completed frame and returns to the base after a descriptor marked end-of-ring.

Top module: `rx_ring_wb`

## Requirements
- R1: After reset the missed-frame count is 0, both completion pulses are low, and the first accepted frame uses the descriptor at the ring base.
- R2: While idle, the engine issues reads of the current descriptor's status word (offset 0) and buffer pointer (offset 8). All memory requests are word aligned, and read data is expected on mem_rdata_i in the cycle after the request.
- R3: Byte k of an accepted frame is written in the same cycle it is presented, to buffer pointer + k. The write is a single-lane access with byte enable bit (address mod 4) set and the byte replicated on all lanes.
- R4: The cycle after the last byte, the engine writes the status word back to descriptor offset 0 with all byte enables set. In that word, bit 31 = 0, bit 30 keeps the end-of-ring value, bits 29 and 28 = 1, and bits 12:0 hold the stored byte count including the 4 CRC bytes.
- R5: If rx_err_i is high on any byte of the frame, status bit 19 (CRC error) and bit 21 (error summary) are set.
- R6: A frame of fewer than MIN_LEN (64) bytes sets bit 20 (runt) and bit 21.
- R7: Bytes beyond the buffer size (bits 12:0 of the status word the engine read) are not written. The length field then equals the buffer size, and bits 22 (overlong) and 21 are set. A frame exactly the buffer size is not overlong.
- R8: The cycle after the status writeback, rx_ok_o pulses for one cycle if bit 21 is clear and rx_err_o pulses if it is set. The two pulses are never high together.
- R9: Each writeback moves the current descriptor 16 bytes further. After a descriptor with bit 30 set, the engine returns to the base given by ring_base_i (address bits 31:8).
- R10: A frame that starts while the cached descriptor has bit 31 clear causes no memory write and adds 1 to miss_cnt_o. The ring does not advance.
- R11: miss_clr_i sets miss_cnt_o to 0 on the next cycle. A drop in the same cycle leaves the count at 1.
- R12: A frame start accepted at least 4 idle cycles after a last byte is taken. A start 1 to 4 cycles after the last byte, before the next descriptor is read in, is dropped and counted as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_base_i | input | 24 | Ring base address bits 31:8 |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_sof_i | input | 1 | First byte of frame |
| rx_eof_i | input | 1 | Last byte of frame |
| rx_data_i | input | 8 | Receive byte |
| rx_err_i | input | 1 | CRC error indication, any byte of frame |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write (1) or read (0) |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_be_o | output | 4 | Byte lane enables for writes |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after request |
| rx_ok_o | output | 1 | Clean frame completed pulse |
| rx_err_o | output | 1 | Errored frame completed pulse |
| miss_clr_i | input | 1 | Clear missed-frame counter |
| miss_cnt_o | output | 32 | Missed-frame count |

## Verification
Byte writes are combinational on the presented byte, so the bench checks each byte's address, lane and data 1 ns after driving it, in the same cycle. The status writeback is due one cycle after the last byte, and the completion pulse one cycle after that. A monitor samples 2 ns after each falling edge and stamps both events with a cycle counter. The bench then compares those stamps against the last-byte cycle, plus 1 for the writeback and plus 2 for the pulse. Missed-frame counts and clears take effect at the next edge and are read several cycles later. The spacing requirement is tested by starting a frame two cycles after the previous last byte.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned BE_W        = WORD_W / DATA_W;
  localparam int unsigned LANE_W      = $clog2(BE_W);
  localparam int unsigned RING_ALIGN  = 8;
  localparam int unsigned DESC_SHIFT  = 4;
  localparam int unsigned BUF_PTR_OFF = 8;
  localparam int unsigned LEN_W       = 13;

  localparam int unsigned B_OWN  = 31;
  localparam int unsigned B_EOR  = 30;
  localparam int unsigned B_FS   = 29;
  localparam int unsigned B_LS   = 28;
  localparam int unsigned B_WDOG = 22;
  localparam int unsigned B_RES  = 21;
  localparam int unsigned B_RUNT = 20;
  localparam int unsigned B_CRC  = 19;

  typedef enum logic [2:0] {
    ST_POLL_ST,
    ST_POLL_BUF,
    ST_RECV,
    ST_DROP,
    ST_WB
  } rx_state_e;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_STAT,
    RD_BUF
  } rd_kind_e;
endpackage

// File: rtl/rx_ring_ptr.sv
module rx_ring_ptr import rx_ring_pkg::*; #(
  parameter int unsigned IDX_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [ADDR_W-1:RING_ALIGN]   base_i,
  input  logic                         advance_i,
  input  logic                         wrap_i,
  output logic [ADDR_W-1:0]            desc_addr_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        idx_q <= '0;
    else if (advance_i) idx_q <= wrap_i ? '0 : idx_q + 1'b1;
  end

  assign desc_addr_o = {base_i, {RING_ALIGN{1'b0}}} + (ADDR_W'(idx_q) << DESC_SHIFT);
endmodule

// File: rtl/rx_miss_cnt.sv
module rx_miss_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= inc_i ? W'(1) : '0;  // no event lost on a coincident clear
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rx_ring_status.sv
module rx_ring_status import rx_ring_pkg::*; #(
  parameter int unsigned CNT_W   = LEN_W + 1,
  parameter int unsigned MIN_LEN = 64
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [LEN_W-1:0]  size_i,
  input  logic              eor_i,
  input  logic              crc_i,
  output logic [WORD_W-1:0] word_o,
  output logic              has_err_o
);
  logic             ovl, runt;
  logic [LEN_W-1:0] stored;

  assign ovl       = cnt_i > {{(CNT_W-LEN_W){1'b0}}, size_i};
  assign runt      = cnt_i < CNT_W'(MIN_LEN);
  assign stored    = ovl ? size_i : cnt_i[LEN_W-1:0];
  assign has_err_o = crc_i | runt | ovl;

  always_comb begin
    word_o               = '0;
    word_o[B_EOR]        = eor_i;
    word_o[B_FS]         = 1'b1;
    word_o[B_LS]         = 1'b1;
    word_o[B_WDOG]       = ovl;
    word_o[B_RES]        = has_err_o;
    word_o[B_RUNT]       = runt;
    word_o[B_CRC]        = crc_i;
    word_o[LEN_W-1:0]    = stored;
  end
endmodule

// File: rtl/rx_ring_wb.sv
module rx_ring_wb import rx_ring_pkg::*; #(
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned MISS_W  = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:RING_ALIGN] ring_base_i,
  input  logic                       rx_valid_i,
  input  logic                       rx_sof_i,
  input  logic                       rx_eof_i,
  input  logic [DATA_W-1:0]          rx_data_i,
  input  logic                       rx_err_i,
  output logic                       mem_req_o,
  output logic                       mem_we_o,
  output logic [ADDR_W-1:0]          mem_addr_o,
  output logic [BE_W-1:0]            mem_be_o,
  output logic [WORD_W-1:0]          mem_wdata_o,
  input  logic [WORD_W-1:0]          mem_rdata_i,
  output logic                       rx_ok_o,
  output logic                       rx_err_o,
  input  logic                       miss_clr_i,
  output logic [MISS_W-1:0]          miss_cnt_o
);
  localparam int unsigned CNT_W = LEN_W + 1;

  rx_state_e         state_q, state_d;
  rd_kind_e          rd_kind_q, rd_kind_d;
  logic [WORD_W-1:0] cache_st_q;
  logic [ADDR_W-1:0] cache_buf_q;
  logic              got_st_q, cache_ok_q;
  logic [CNT_W-1:0]  byte_cnt_q, cnt_inc, wr_off;
  logic              crc_q;
  logic              ok_q, err_q;

  logic              frame_start, accept, in_buf, start_ok, byte_wr, miss_inc;
  logic [ADDR_W-1:0] desc_addr, byte_addr;
  logic [WORD_W-1:0] status_word;
  logic              has_err;
  logic              unused_st;

  assign unused_st = ^cache_st_q[B_FS:LEN_W];

  rx_ring_ptr #(.IDX_W(IDX_W)) ptr_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_i      (ring_base_i),
    .advance_i   (state_q == ST_WB),
    .wrap_i      (cache_st_q[B_EOR]),
    .desc_addr_o (desc_addr)
  );

  rx_miss_cnt #(.W(MISS_W)) miss_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (miss_clr_i),
    .inc_i  (miss_inc),
    .cnt_o  (miss_cnt_o)
  );

  rx_ring_status #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) stat_i (
    .cnt_i     (byte_cnt_q),
    .size_i    (cache_st_q[LEN_W-1:0]),
    .eor_i     (cache_st_q[B_EOR]),
    .crc_i     (crc_q),
    .word_o    (status_word),
    .has_err_o (has_err)
  );

  assign frame_start = rx_valid_i & rx_sof_i;
  assign accept      = cache_ok_q & cache_st_q[B_OWN];
  assign wr_off      = (state_q == ST_RECV) ? byte_cnt_q : '0;
  assign in_buf      = wr_off < {1'b0, cache_st_q[LEN_W-1:0]};
  assign byte_addr   = cache_buf_q + ADDR_W'(wr_off);
  assign cnt_inc     = (&byte_cnt_q) ? byte_cnt_q : byte_cnt_q + 1'b1;

  always_comb begin
    state_d     = state_q;
    rd_kind_d   = RD_NONE;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_be_o    = '0;
    mem_wdata_o = '0;
    start_ok    = 1'b0;
    byte_wr     = 1'b0;
    miss_inc    = 1'b0;
    unique case (state_q)
      ST_POLL_ST, ST_POLL_BUF: begin
        if (frame_start) begin
          if (accept) begin
            start_ok = 1'b1;
            byte_wr  = in_buf;
            state_d  = rx_eof_i ? ST_WB : ST_RECV;
          end else begin
            miss_inc = 1'b1;
            state_d  = rx_eof_i ? ST_POLL_ST : ST_DROP;
          end
        end else begin
          mem_req_o = 1'b1;
          if (state_q == ST_POLL_ST) begin
            mem_addr_o = desc_addr;
            rd_kind_d  = RD_STAT;
            state_d    = ST_POLL_BUF;
          end else begin
            mem_addr_o = desc_addr + ADDR_W'(BUF_PTR_OFF);
            rd_kind_d  = RD_BUF;
            state_d    = ST_POLL_ST;
          end
        end
      end
      ST_RECV: begin
        if (rx_valid_i) begin
          byte_wr = in_buf;
          if (rx_eof_i) state_d = ST_WB;
        end
      end
      ST_DROP: begin
        if (rx_valid_i && rx_eof_i) state_d = ST_POLL_ST;
      end
      ST_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_addr;
        mem_be_o    = '1;
        mem_wdata_o = status_word;
        state_d     = ST_POLL_ST;
        if (frame_start) begin
          miss_inc = 1'b1;
          if (!rx_eof_i) state_d = ST_DROP;
        end
      end
      default: state_d = ST_POLL_ST;
    endcase
    if (byte_wr) begin
      mem_req_o   = 1'b1;
      mem_we_o    = 1'b1;
      mem_addr_o  = {byte_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
      mem_be_o    = BE_W'(1) << byte_addr[LANE_W-1:0];
      mem_wdata_o = {BE_W{rx_data_i}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_POLL_ST;
      rd_kind_q   <= RD_NONE;
      cache_st_q  <= '0;
      cache_buf_q <= '0;
      got_st_q    <= 1'b0;
      cache_ok_q  <= 1'b0;
      byte_cnt_q  <= '0;
      crc_q       <= 1'b0;
      ok_q        <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q   <= state_d;
      rd_kind_q <= rd_kind_d;
      if (start_ok) begin
        byte_cnt_q <= CNT_W'(1);
        crc_q      <= rx_err_i;
      end else if (state_q == ST_RECV && rx_valid_i) begin
        byte_cnt_q <= cnt_inc;
        crc_q      <= crc_q | rx_err_i;
      end
      // cache refresh from the poll reads
      if (rd_kind_q == RD_STAT) begin
        cache_st_q <= mem_rdata_i;
        got_st_q   <= 1'b1;
      end else if (rd_kind_q == RD_BUF) begin
        cache_buf_q <= mem_rdata_i;
        cache_ok_q  <= got_st_q;
      end
      if (state_q == ST_WB) begin
        got_st_q   <= 1'b0;
        cache_ok_q <= 1'b0;
      end
      ok_q  <= (state_q == ST_WB) && !has_err;
      err_q <= (state_q == ST_WB) && has_err;
    end
  end

  assign rx_ok_o  = ok_q;
  assign rx_err_o = err_q;
endmodule

// File: rtl/rx_ring_wb_chk.sv
module rx_ring_wb_chk import rx_ring_pkg::*; #(
  parameter int unsigned MISS_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [BE_W-1:0]   mem_be_o,
  input logic [WORD_W-1:0] mem_wdata_o,
  input logic              rx_ok_o,
  input logic              rx_err_o,
  input logic              miss_clr_i,
  input logic [MISS_W-1:0] miss_cnt_o
);
  a_r2_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[LANE_W-1:0] == '0);

  a_r3_single_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_be_o != '1) |-> $countones(mem_be_o) == 1);

  a_r4_wb_releases_desc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_be_o == '1) |-> (!mem_wdata_o[B_OWN] && mem_addr_o[DESC_SHIFT-1:0] == '0));

  a_r8_pulse_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_ok_o && rx_err_o));

  a_r8_ok_follows_clean_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ok_o |-> $past(mem_we_o && mem_be_o == '1 && !mem_wdata_o[B_RES]));

  a_r8_err_follows_bad_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_o |-> $past(mem_we_o && mem_be_o == '1 && mem_wdata_o[B_RES]));

  a_r11_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_clr_i |=> miss_cnt_o <= MISS_W'(1));

  a_r10_miss_steps_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_clr_i |=> (miss_cnt_o == $past(miss_cnt_o) || miss_cnt_o == $past(miss_cnt_o) + 1'b1));
endmodule

bind rx_ring_wb rx_ring_wb_chk #(.MISS_W(MISS_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_be_o    (mem_be_o),
  .mem_wdata_o (mem_wdata_o),
  .rx_ok_o     (rx_ok_o),
  .rx_err_o    (rx_err_o),
  .miss_clr_i  (miss_clr_i),
  .miss_cnt_o  (miss_cnt_o)
);

// File: tb/rx_ring_wb_tb_top.sv
`timescale 1ns/1ps
module rx_ring_wb_tb_top;
  localparam int DESC0 = 32'h100;
  localparam int BUF0  = 32'h1000;
  localparam int BSTEP = 32'h200;
  localparam int BSIZE = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0, miss_clr = 0;
  logic [7:0]  rx_data = '0;
  logic        mem_req, mem_we, rx_ok, rx_bad;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, miss_cnt;
  logic [3:0]  mem_be;
  logic [31:0] mem [0:2047];

  int checks = 0, errors = 0, cyc = 0;
  int eof_cyc = 0, take_eof = 0, wb_cyc = -10, ok_cyc = -10, err_cyc = -10;
  int exp_idx = 0;
  logic [31:0] wb_addr = '0;
  bit poll_st_seen = 0, poll_buf_seen = 0;

  always #5 clk = ~clk;

  rx_ring_wb dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ring_base_i(24'h000001),
    .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof),
    .rx_data_i(rx_data), .rx_err_i(rx_err),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .rx_ok_o(rx_ok), .rx_err_o(rx_bad), .miss_clr_i(miss_clr), .miss_cnt_o(miss_cnt)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[12:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[12:2]];
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (mem_req && !mem_we && mem_addr == DESC0)     poll_st_seen = 1;
      if (mem_req && !mem_we && mem_addr == DESC0 + 8) poll_buf_seen = 1;
      if (mem_req && mem_we && mem_be == 4'hF) begin wb_cyc = cyc; wb_addr = mem_addr; end
      if (rx_ok)  ok_cyc  = cyc;
      if (rx_bad) err_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] get_byte(input int a);
    return mem[a[12:2]][8*a[1:0] +: 8];
  endfunction

  task automatic arm(input int i);
    mem[(DESC0 + 16*i) >> 2]     = 32'h8000_0000 | BSIZE | ((i == 3) ? 32'h4000_0000 : 0);
    mem[(DESC0 + 16*i + 8) >> 2] = BUF0 + BSTEP*i;
    for (int w = 0; w < BSTEP/4; w++) mem[((BUF0 + BSTEP*i) >> 2) + w] = 32'hEEEE_EEEE;
  endtask

  function automatic logic [7:0] pat(input int sd, input int k);
    return 8'((sd + k*7) & 8'hFF);
  endfunction

  task automatic send(input int len, input bit err, input bit take, input int sd, input bit clr);
    int bufa = BUF0 + BSTEP*exp_idx;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (k == 0); rx_eof = (k == len-1);
      rx_data = pat(sd, k); rx_err = err && (k == len-1);
      miss_clr = clr && (k == 0);
      #1;
      if (take && k < BSIZE) begin
        chk(mem_we && mem_addr == ((bufa + k) & ~3) && mem_be == (4'b1 << ((bufa + k) & 3))
            && mem_wdata[7:0] == pat(sd, k), "R3", "byte write", mem_addr, (bufa + k) & ~3);
      end else if (take) begin
        chk(!mem_we, "R7", "write past buffer", mem_addr, 0);
      end else begin
        chk(!mem_we, "R10", "write on dropped frame", mem_addr, 0);
      end
      if (k == len-1) begin eof_cyc = cyc; if (take) take_eof = cyc; end
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0; miss_clr = 0;
  endtask

  task automatic finish(input int len, input bit err, input int sd);
    int stored = (len > BSIZE) ? BSIZE : len;
    bit ovl = len > BSIZE, runt = len < 64, res;
    logic [31:0] exp;
    string tag;
    int bad = 0;
    int bufa = BUF0 + BSTEP*exp_idx;
    int da = DESC0 + 16*exp_idx;
    res = ovl | runt | err;
    exp = 32'h3000_0000 | stored | ((exp_idx == 3) ? 32'h4000_0000 : 0)
        | (ovl ? 32'h0040_0000 : 0) | (res ? 32'h0020_0000 : 0)
        | (runt ? 32'h0010_0000 : 0) | (err ? 32'h0008_0000 : 0);
    tag = ovl ? "R7" : runt ? "R6" : err ? "R5" : "R4";
    repeat (5) @(negedge clk);
    chk(mem[da >> 2] == exp, tag, "status word", mem[da >> 2], exp);
    chk(wb_cyc == take_eof + 1, "R4", "writeback cycle", wb_cyc, take_eof + 1);
    chk(wb_addr == da, "R9", "descriptor address", wb_addr, da);
    if (res) chk(err_cyc == wb_cyc + 1 && ok_cyc != wb_cyc + 1, "R8", "err pulse cycle", err_cyc, wb_cyc + 1);
    else     chk(ok_cyc == wb_cyc + 1 && err_cyc != wb_cyc + 1, "R8", "ok pulse cycle", ok_cyc, wb_cyc + 1);
    for (int k = 0; k < stored; k++) if (get_byte(bufa + k) != pat(sd, k)) bad++;
    chk(bad == 0, tag, "buffer content mismatches", bad, 0);
    chk(get_byte(bufa + stored) == 8'hEE, "R7", "byte past stored length", get_byte(bufa + stored), 8'hEE);
    exp_idx = (exp_idx + 1) % 4;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lens[8] = '{1, 2, 63, 64, 65, 99, 100, 101};
    for (int w = 0; w < 2048; w++) mem[w] = '0;
    for (int i = 0; i < 4; i++) arm(i);
    repeat (4) @(negedge clk);
    chk(miss_cnt == 0 && !rx_ok && !rx_bad, "R1", "reset outputs", miss_cnt, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    chk(poll_st_seen && poll_buf_seen, "R2", "idle descriptor reads", {poll_st_seen, poll_buf_seen}, 2'b11);
    chk(miss_cnt == 0 && !rx_ok && !rx_bad, "R1", "idle after reset", miss_cnt, 0);

    send(70, 0, 1, 8'h11, 0);  finish(70, 0, 8'h11);   // R1 first frame at base
    send(80, 1, 1, 8'h22, 0);  finish(80, 1, 8'h22);   // R5
    send(20, 0, 1, 8'h33, 0);  finish(20, 0, 8'h33);   // R6
    send(110, 0, 1, 8'h44, 0); finish(110, 0, 8'h44);  // R7, end-of-ring

    // R10: wrapped to descriptor 0, which software has not returned
    repeat (6) @(negedge clk);
    send(30, 0, 0, 8'h55, 0);
    repeat (4) @(negedge clk);
    chk(miss_cnt == 1, "R10", "missed count", miss_cnt, 1);
    chk(get_byte(BUF0) == 8'h11, "R10", "buffer untouched", get_byte(BUF0), 8'h11);

    // R11: clear
    @(negedge clk); miss_clr = 1;
    @(negedge clk); miss_clr = 0;
    #3;
    chk(miss_cnt == 0, "R11", "cleared count", miss_cnt, 0);

    // length sweep across runt and buffer-size boundaries, with ring wrap (R9)
    for (int i = 0; i < 8; i++) begin
      arm(exp_idx);
      repeat (6) @(negedge clk);
      send(lens[i], (i % 3) == 2, 1, 8'h60 + i, 0);
      finish(lens[i], (i % 3) == 2, 8'h60 + i);
    end

    // R12: frame starting two cycles after a last byte is dropped
    arm(exp_idx); arm((exp_idx + 1) % 4);
    repeat (6) @(negedge clk);
    send(70, 0, 1, 8'h70, 0);
    send(40, 0, 0, 8'h71, 0);
    finish(70, 0, 8'h70);
    chk(miss_cnt == 1, "R12", "early start counted", miss_cnt, 1);

    // R11: clear coincident with a drop leaves 1
    arm(exp_idx); arm((exp_idx + 1) % 4);
    repeat (6) @(negedge clk);
    send(70, 0, 1, 8'h80, 0);
    send(40, 0, 0, 8'h81, 1);
    finish(70, 0, 8'h80);
    chk(miss_cnt == 1, "R11", "clear with coincident drop", miss_cnt, 1);

    // R10: drops did not advance the ring
    repeat (6) @(negedge clk);
    send(64, 0, 1, 8'h90, 0);
    finish(64, 0, 8'h90);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule